// File: doc/BRIEF.md
# External Memory Controller Mode and Remap Front End

This block is the control and status front end of an external memory controller. It holds three mode bits: an enable, a boot-time address mirror and a low-power request. It also presents two status bits that the memory engine drives: busy and write-buffer-not-empty. Software reaches both words over a simple register bus. The control word sits at offset 0x0. The read-only status word sits at offset 0x4.

Every incoming memory access passes through the block, which makes one of three decisions for it. It can forward the access with its region unchanged, forward it with the region remapped while the mirror bit is set, or reject it with an error while the controller is disabled or in low-power mode. The registers stay reachable in every mode.

There are two resets, each active low and asynchronous. Power-on reset initialises everything. Warm reset preserves the mirror bit and loads different status values. The block also tells the engine whether refresh is allowed.

Top module: `memctl_mode_unit`

## Requirements
- R1: While power-on reset (`por_n`) is low, the control word reads 0x3 (enable=1, mirror=1, low-power=0). The status word reads 0x1 (busy=1, write-buffer=0).
- R2: While warm reset (`warm_n`) is low, enable becomes 1 and low-power becomes 0. The mirror bit keeps its value, and the status word reads 0x0.
- R3: Control word at offset 0x0 has this layout: bit 0 = enable, bit 1 = mirror, bit 2 = low-power. A write lands on the next rising edge. Bits 31:3 read 0 whatever was written.
- R4: Status word at offset 0x4 has this layout: bit 0 = busy, bit 1 = write-buffer-not-empty. Each bit shows the engine input as sampled at the previous rising edge. Writes to 0x4 have no effect. Any other offset reads 0. `reg_rdata` is 0 when `reg_sel` is low.
- R5: A control write while the sampled status has busy=1 or write-buffer=1 leaves enable and low-power unchanged. The mirror bit is still written.
- R6: Region codes are: 0 = static CS0, 1 = static CS1, 4 = dynamic CS0. While mirror=1, regions 0 and 4 come out as 1 on `acc_region_out`. All other codes, and every code while mirror=0, pass through unchanged.
- R7: The access decision is combinational. When `acc_valid`=1 and the controller is disabled or in low-power mode, the block sets `acc_err`=1 and `acc_go`=0. Otherwise `acc_valid` is copied to `acc_go` with `acc_err`=0. The two are never high together.
- R8: `ctl_enable` follows enable and `lp_req` follows low-power. `refresh_ok` equals enable, so refresh continues in low-power mode.
- R9: Register reads and writes behave identically while the controller is disabled or in low-power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_n | input | 1 | Warm reset, active low, asynchronous |
| reg_sel | input | 1 | Register bus select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| eng_busy | input | 1 | Engine busy / self-refresh indication |
| eng_wbuf | input | 1 | Engine write buffer holds data |
| acc_valid | input | 1 | Memory access request |
| acc_region | input | 3 | Requested region code |
| acc_go | output | 1 | Access forwarded to engine |
| acc_err | output | 1 | Access rejected with bus error |
| acc_region_out | output | 3 | Region after mirror steering |
| ctl_enable | output | 1 | Enable level |
| lp_req | output | 1 | Low-power request |
| refresh_ok | output | 1 | Refresh permitted |

## Verification
A control write can land in the same cycle as a memory access. The access must be judged on the mode bits that were in force before the write edge, and the write must then take effect under the idle rule. The random phase drives register writes, access requests and engine status together every cycle. A bench model steps the mode bits only at the edge, after it has judged that cycle's access. Directed cases cover the harder combinations: a mode write while busy is high, and a mode write while only the write-buffer flag is set. In both, the mirror bit is expected to change while enable and low-power stay put.

// File: rtl/memctl_pkg.sv
package memctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned REGION_W = 3;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned STAT_OFS = 4;
  localparam int unsigned STAT_N   = 2;

  localparam logic [REGION_W-1:0] RG_ST0 = 3'd0;
  localparam logic [REGION_W-1:0] RG_ST1 = 3'd1;
  localparam logic [REGION_W-1:0] RG_DY0 = 3'd4;

  typedef struct packed {
    logic lp;
    logic mirror;
    logic en;
  } ctrl_t;

  function automatic logic [REGION_W-1:0] steer_region(
    input logic [REGION_W-1:0] r, input logic mir);
    if (mir && (r == RG_ST0 || r == RG_DY0)) return RG_ST1;
    return r;
  endfunction

  function automatic ctrl_t next_ctrl(input ctrl_t cur, input ctrl_t req,
                                      input logic hold);
    ctrl_t n;
    n.mirror = req.mirror;
    n.en     = hold ? cur.en : req.en;
    n.lp     = hold ? cur.lp : req.lp;
    return n;
  endfunction

  function automatic logic access_open(input ctrl_t c);
    return c.en & ~c.lp;
  endfunction
endpackage

// File: rtl/memctl_ctrl_regs.sv
module memctl_ctrl_regs
  import memctl_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  warm_n,
  input  logic  ctl_wr,
  input  ctrl_t wr_bits,
  input  logic  stat_busy,
  input  logic  stat_wbuf,
  output ctrl_t ctrl,
  output logic  mode_hold
);
  logic  en_q, lp_q, mir_q;
  ctrl_t cur, nxt;

  assign mode_hold = stat_busy | stat_wbuf;
  assign cur       = '{lp: lp_q, mirror: mir_q, en: en_q};
  assign nxt       = next_ctrl(cur, wr_bits, mode_hold);
  assign ctrl      = cur;

  always_ff @(posedge clk or negedge por_n or negedge warm_n) begin
    if (!por_n) begin
      en_q <= 1'b1;
      lp_q <= 1'b0;
    end else if (!warm_n) begin
      en_q <= 1'b1;
      lp_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q <= nxt.en;
      lp_q <= nxt.lp;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                mir_q <= 1'b1;
    else if (ctl_wr && warm_n) mir_q <= nxt.mirror;
  end

  assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (ctl_wr && mode_hold) |=> (ctrl.en == $past(ctrl.en)) && (ctrl.lp == $past(ctrl.lp)));

  assert_mirror_written_R5: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    ctl_wr |=> ctrl.mirror == $past(wr_bits.mirror));

  assert_idle_write_R3: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (ctl_wr && !mode_hold) |=> (ctrl.en == $past(wr_bits.en)) && (ctrl.lp == $past(wr_bits.lp)));
endmodule

// File: rtl/memctl_status_sync.sv
module memctl_status_sync #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] POR_VAL  = '0,
  parameter logic [N-1:0] WARM_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         warm_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge por_n or negedge warm_n) begin
      if (!por_n)       q[g] <= POR_VAL[g];
      else if (!warm_n) q[g] <= WARM_VAL[g];
      else              q[g] <= d[g];
    end
  end

  assert_status_tracks_R4: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    1'b1 |=> q == $past(d));
endmodule

// File: rtl/memctl_region_map.sv
module memctl_region_map
  import memctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_any_n,
  input  logic                acc_valid,
  input  logic [REGION_W-1:0] acc_region,
  input  ctrl_t               ctrl,
  output logic                acc_go,
  output logic                acc_err,
  output logic [REGION_W-1:0] acc_region_out
);
  logic gate_open;

  assign gate_open      = access_open(ctrl);
  assign acc_go         = acc_valid & gate_open;
  assign acc_err        = acc_valid & ~gate_open;
  assign acc_region_out = steer_region(acc_region, ctrl.mirror);

  assert_reject_closed_R7: assert property (@(posedge clk) disable iff (!rst_any_n)
    (acc_valid && (!ctrl.en || ctrl.lp)) |-> (acc_err && !acc_go));

  assert_go_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_any_n)
    $onehot0({acc_go, acc_err}));

  assert_mirror_dy0_R6: assert property (@(posedge clk) disable iff (!rst_any_n)
    (ctrl.mirror && acc_region == RG_DY0) |-> acc_region_out == RG_ST1);

  assert_nomirror_pass_R6: assert property (@(posedge clk) disable iff (!rst_any_n)
    !ctrl.mirror |-> acc_region_out == acc_region);
endmodule

// File: rtl/memctl_mode_unit.sv
module memctl_mode_unit
  import memctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                warm_n,
  input  logic                reg_sel,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                eng_busy,
  input  logic                eng_wbuf,
  input  logic                acc_valid,
  input  logic [REGION_W-1:0] acc_region,
  output logic                acc_go,
  output logic                acc_err,
  output logic [REGION_W-1:0] acc_region_out,
  output logic                ctl_enable,
  output logic                lp_req,
  output logic                refresh_ok
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam int unsigned CTRL_N = $bits(ctrl_t);

  ctrl_t             ctrl;
  ctrl_t             wr_bits;
  logic [STAT_N-1:0] stat_q;
  logic              ctl_wr, mode_hold, rst_any_n;
  logic              unused_wdata_hi;

  assign rst_any_n       = por_n & warm_n;
  assign ctl_wr          = reg_sel & reg_wr & (reg_addr == A_CTRL);
  assign wr_bits         = ctrl_t'(reg_wdata[CTRL_N-1:0]);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_N];

  memctl_ctrl_regs u_ctrl (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .ctl_wr(ctl_wr),
    .wr_bits(wr_bits), .stat_busy(stat_q[0]), .stat_wbuf(stat_q[1]),
    .ctrl(ctrl), .mode_hold(mode_hold)
  );

  memctl_status_sync #(.N(STAT_N), .POR_VAL(2'b01), .WARM_VAL(2'b00)) u_stat (
    .clk(clk), .por_n(por_n), .warm_n(warm_n),
    .d({eng_wbuf, eng_busy}), .q(stat_q)
  );

  memctl_region_map u_map (
    .clk(clk), .rst_any_n(rst_any_n), .acc_valid(acc_valid),
    .acc_region(acc_region), .ctrl(ctrl), .acc_go(acc_go),
    .acc_err(acc_err), .acc_region_out(acc_region_out)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      if (reg_addr == A_CTRL)      reg_rdata[CTRL_N-1:0] = ctrl;
      else if (reg_addr == A_STAT) reg_rdata[STAT_N-1:0] = stat_q;
    end
  end

  assign ctl_enable = ctrl.en;
  assign lp_req     = ctrl.lp;
  assign refresh_ok = ctrl.en;

  assert_no_refresh_off_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
    !ctl_enable |-> !refresh_ok);

  assert_refresh_in_lp_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
    (ctl_enable && lp_req) |-> refresh_ok);

  assert_warm_keeps_mirror_R2: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_n && $past(warm_n)) |-> ctrl.mirror == $past(ctrl.mirror));
endmodule

// File: tb/memctl_mode_unit_tb_top.sv
`timescale 1ns/1ps
module memctl_mode_unit_tb_top;
  logic clk = 1'b0;
  logic por_n, warm_n, reg_sel, reg_wr, eng_busy, eng_wbuf, acc_valid;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0]  acc_region, acc_region_out;
  logic acc_go, acc_err, ctl_enable, lp_req, refresh_ok;

  int checks = 0;
  int errors = 0;
  logic m_en, m_mir, m_lp, m_busy, m_wbuf;

  always #2.5 clk = ~clk;

  memctl_mode_unit dut_i (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_wbuf(eng_wbuf), .acc_valid(acc_valid),
    .acc_region(acc_region), .acc_go(acc_go), .acc_err(acc_err),
    .acc_region_out(acc_region_out), .ctl_enable(ctl_enable), .lp_req(lp_req),
    .refresh_ok(refresh_ok)
  );

  function automatic logic [2:0] b_map(input logic [2:0] r, input logic mir);
    return (mir && (r == 3'd0 || r == 3'd4)) ? 3'd1 : r;
  endfunction

  function automatic logic [31:0] b_read(input logic [3:0] a);
    if (a == 4'h0) return {29'd0, m_lp, m_mir, m_en};
    if (a == 4'h4) return {30'd0, m_wbuf, m_busy};
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic sel, input logic wr, input logic [3:0] addr,
                     input logic [31:0] wd, input logic busy, input logic wbuf,
                     input logic av, input logic [2:0] rg, input string tag);
    logic open;
    @(negedge clk);
    reg_sel = sel; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    eng_busy = busy; eng_wbuf = wbuf; acc_valid = av; acc_region = rg;
    #1;
    open = m_en & ~m_lp;
    check({tag, " R7 go"},  {31'd0, acc_go},  {31'd0, av & open});
    check({tag, " R7 err"}, {31'd0, acc_err}, {31'd0, av & ~open});
    if (av) check({tag, " R6 region"}, {29'd0, acc_region_out}, {29'd0, b_map(rg, m_mir)});
    check({tag, " R8 outs"}, {29'd0, ctl_enable, lp_req, refresh_ok}, {29'd0, m_en, m_lp, m_en});
    check({tag, " rdata"}, reg_rdata, sel ? b_read(addr) : 32'd0);
    @(posedge clk);
    if (sel && wr && addr == 4'h0) begin
      if (!(m_busy | m_wbuf)) begin m_en = wd[0]; m_lp = wd[2]; end
      m_mir = wd[1];
    end
    m_busy = busy; m_wbuf = wbuf;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    por_n = 1'b0; warm_n = 1'b1; reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; eng_busy = 1'b0; eng_wbuf = 1'b0; acc_valid = 1'b0; acc_region = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b1; reg_addr = 4'h0; #1;
    check("R1 ctrl after POR", reg_rdata, 32'h3);
    reg_addr = 4'h4; #1;
    check("R1 status after POR", reg_rdata, 32'h1);
    acc_valid = 1'b1; acc_region = 3'd0; #1;
    check("R6 mirror at boot", {29'd0, acc_region_out}, 32'd1);
    acc_valid = 1'b0; reg_sel = 1'b0;
    m_en = 1; m_mir = 1; m_lp = 0; m_busy = 1; m_wbuf = 0;
    por_n = 1'b1;

    cyc(1, 0, 4'h4, 0, 0, 0, 1, 3'd4, "R4 busy seen");
    cyc(1, 0, 4'h4, 0, 0, 0, 1, 3'd4, "R6 dy0 mirrored");
    cyc(1, 1, 4'h0, 32'h1, 0, 0, 0, 0, "R3 clear mirror");
    cyc(1, 0, 4'h0, 0, 0, 0, 1, 3'd0, "R6 cs0 direct");
    cyc(1, 0, 4'h0, 0, 0, 0, 1, 3'd4, "R6 dy0 direct");
    cyc(1, 0, 4'h0, 0, 1, 0, 0, 0, "R5 set busy");
    cyc(1, 1, 4'h0, 32'h6, 1, 0, 1, 3'd2, "R5 write while busy");
    cyc(1, 0, 4'h0, 0, 0, 1, 0, 0, "R5 after busy write");
    cyc(1, 1, 4'h0, 32'h4, 0, 1, 0, 0, "R5 write while wbuf");
    cyc(1, 0, 4'h0, 0, 0, 0, 0, 0, "R5 after wbuf write");
    cyc(1, 1, 4'h0, 32'h5, 0, 0, 0, 0, "R3 enter lp");
    cyc(1, 0, 4'h0, 0, 0, 0, 1, 3'd1, "R7 lp reject");
    cyc(1, 1, 4'h4, 32'hFF, 0, 0, 1, 3'd3, "R9 write status in lp");
    cyc(1, 0, 4'h4, 0, 0, 0, 0, 0, "R4 status write ignored");
    cyc(1, 1, 4'h0, 32'h0, 0, 0, 0, 0, "R9 disable");
    cyc(1, 0, 4'h0, 0, 0, 0, 1, 3'd5, "R8 disabled no refresh");
    cyc(1, 1, 4'h0, 32'hFFFF_FFF9, 0, 0, 0, 0, "R3 reserved write");
    cyc(1, 0, 4'h0, 0, 0, 0, 0, 0, "R3 reserved read zero");
    cyc(1, 0, 4'h8, 0, 0, 0, 0, 0, "R4 other offset");
    cyc(0, 0, 4'h0, 0, 0, 0, 0, 0, "R4 no select");
    cyc(1, 1, 4'h0, 32'h5, 0, 0, 0, 0, "R2 prep lp");

    @(negedge clk);
    eng_busy = 1'b1; warm_n = 1'b0; reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 4'h4;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    check("R2 status in warm reset", reg_rdata, 32'h0);
    reg_addr = 4'h0; #1;
    check("R2 ctrl in warm reset", reg_rdata, 32'h1);
    warm_n = 1'b1; eng_busy = 1'b0;
    m_en = 1; m_lp = 0; m_busy = 0; m_wbuf = 0;
    cyc(1, 0, 4'h0, 0, 0, 0, 1, 3'd0, "R2 after warm reset");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 3) * 4);
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom,
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), "rand R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule